// File: doc/BRIEF.md
# USB Receive Data Toggle Filter

This block sits between the packet receiver and the endpoint buffers of a USB device controller. When a data packet has been received, the receiver presents the endpoint number, the direction, whether the PID was DATA0 or DATA1, a CRC-good flag, the bus speed and two room flags. The filter keeps one toggle bit for each endpoint and direction pair. It compares the received PID against the stored bit and decides whether the packet is new data or a repeat of one already taken.

New data that arrives with room available is passed upward, and the stored toggle flips. A repeat means the host missed the previous handshake. The filter drops the repeat without reporting it, but still answers it so that the host stops retrying. A packet with a bad CRC gets no answer at all. The handshake generator receives a two-bit code, and firmware can force any slot back to DATA0 through a clear vector.

Top module: `usb_toggle_filter`

## Requirements
- R1: After reset every endpoint/direction slot expects DATA0, and all output strobes are low.
- R2: A packet with good CRC, a PID equal to the stored toggle and `room_now` high is accepted. `acc_valid` pulses, the slot's toggle flips, and `tog_upd_valid`, `tog_upd_ep`, `tog_upd_dir` and `tog_upd_value` report the new value.
- R3: A good-CRC packet whose PID differs from the stored toggle is dropped. `drop_dup` pulses, `acc_valid` stays low and the toggle does not change.
- R4: A dropped duplicate is always answered with ACK or NYET, whatever the state of `room_now`.
- R5: A packet with bad CRC produces no response code, no accept, no drop and no toggle change.
- R6: Handshake codes are 0 = none, 1 = ACK, 2 = NYET and 3 = NAK. For an accepted or duplicate packet the code is NYET only when `hs_mode` is high and `room_next` is low; otherwise it is ACK.
- R7: A good-CRC packet whose PID matches the toggle, arriving while `room_now` is low, is answered with NAK. It is neither accepted nor dropped, and the toggle is unchanged.
- R8: A set bit `i` of `tog_clr` forces slot `i` (index = endpoint*2 + direction) to DATA0. A clear in the same cycle as an accept on that slot overrides the flip.
- R9: Toggle bits of different endpoint/direction slots are independent.
- R10: All outputs are registered and appear in the cycle after `pkt_valid`, for one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pkt_valid | input | 1 | One-cycle strobe: a received data packet is complete |
| pkt_ep | input | EPW | Endpoint number |
| pkt_dir | input | 1 | Direction bit of the slot |
| pkt_data1 | input | 1 | 1 = DATA1 PID, 0 = DATA0 PID |
| pkt_crc_ok | input | 1 | CRC of the packet was good |
| hs_mode | input | 1 | Bus runs at high speed |
| room_now | input | 1 | Endpoint can store this packet |
| room_next | input | 1 | Endpoint can store a further packet |
| tog_clr | input | 2*NUM_EP | Per-slot force to DATA0 |
| acc_valid | output | 1 | Packet accepted and reported upward |
| drop_dup | output | 1 | Packet discarded as duplicate |
| rsp_valid | output | 1 | A handshake must be sent |
| rsp_code | output | 2 | Handshake code (R6 encoding) |
| tog_upd_valid | output | 1 | Toggle bit was flipped |
| tog_upd_ep | output | EPW | Endpoint of the flipped toggle |
| tog_upd_dir | output | 1 | Direction of the flipped toggle |
| tog_upd_value | output | 1 | New toggle value |

## Verification
The filter is first driven with a stream of alternating DATA0/DATA1 packets, which shows that the toggle advances with every accept. A replay of the previous PID then separates the silent drop from a real accept, because the handshake stays the same while the report differs. A CRC error, a match with no room, and a high-speed run with the next buffer full separate the none, NAK and NYET codes. Clears, issued both alone and together with an accept, and traffic spread over two slots show that the reset path wins over a flip and that slots do not disturb each other.

// File: rtl/usb_toggle_filter.sv
module usb_toggle_filter #(
  parameter int NUM_EP = 16,
  localparam int EPW = (NUM_EP > 1) ? $clog2(NUM_EP) : 1,
  localparam int SLOTS = 2 * NUM_EP
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pkt_valid,
  input  logic [EPW-1:0]   pkt_ep,
  input  logic             pkt_dir,
  input  logic             pkt_data1,
  input  logic             pkt_crc_ok,
  input  logic             hs_mode,
  input  logic             room_now,
  input  logic             room_next,
  input  logic [SLOTS-1:0] tog_clr,
  output logic             acc_valid,
  output logic             drop_dup,
  output logic             rsp_valid,
  output logic [1:0]       rsp_code,
  output logic             tog_upd_valid,
  output logic [EPW-1:0]   tog_upd_ep,
  output logic             tog_upd_dir,
  output logic             tog_upd_value
);

  localparam logic [1:0] HS_NONE = 2'd0;
  localparam logic [1:0] HS_ACK  = 2'd1;
  localparam logic [1:0] HS_NYET = 2'd2;
  localparam logic [1:0] HS_NAK  = 2'd3;

  logic [SLOTS-1:0] tog_q;
  logic [EPW:0]     slot;
  logic             cur, match, good, take, busy, dup, want_nyet;
  logic [1:0]       code;

  assign slot      = {pkt_ep, pkt_dir};
  assign cur       = tog_q[slot];
  assign match     = (pkt_data1 == cur);
  assign good      = pkt_valid & pkt_crc_ok;
  assign take      = good & match & room_now;
  assign busy      = good & match & ~room_now;
  assign dup       = good & ~match;
  assign want_nyet = hs_mode & ~room_next;

  always_comb begin
    if (busy)             code = HS_NAK;
    else if (take || dup) code = want_nyet ? HS_NYET : HS_ACK;
    else                  code = HS_NONE;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tog_q <= '0;
    end else begin
      for (int i = 0; i < SLOTS; i++) begin
        if (tog_clr[i])                     tog_q[i] <= 1'b0;
        else if (take && slot == (EPW+1)'(i)) tog_q[i] <= ~tog_q[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_valid     <= 1'b0;
      drop_dup      <= 1'b0;
      rsp_valid     <= 1'b0;
      rsp_code      <= HS_NONE;
      tog_upd_valid <= 1'b0;
      tog_upd_ep    <= '0;
      tog_upd_dir   <= 1'b0;
      tog_upd_value <= 1'b0;
    end else begin
      acc_valid     <= take;
      drop_dup      <= dup;
      rsp_valid     <= (code != HS_NONE);
      rsp_code      <= code;
      tog_upd_valid <= take;
      tog_upd_ep    <= pkt_ep;
      tog_upd_dir   <= pkt_dir;
      tog_upd_value <= ~cur;
    end
  end

  assert_dup_not_reported_R3: assert property (@(posedge clk) disable iff (!rst_n)
    drop_dup |-> !acc_valid);

  assert_dup_answered_R4: assert property (@(posedge clk) disable iff (!rst_n)
    drop_dup |-> rsp_valid && (rsp_code == HS_ACK || rsp_code == HS_NYET));

  assert_bad_crc_silent_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_valid && !pkt_crc_ok) |=> !rsp_valid && !acc_valid && !drop_dup);

  assert_nyet_needs_hs_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_valid && !hs_mode) |=> rsp_code != HS_NYET);

  assert_accept_flips_R2: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid |-> tog_upd_valid);

  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !pkt_valid |=> !rsp_valid && !acc_valid && !drop_dup);

endmodule

// File: tb/test_usb_toggle_filter.sv
module test_usb_toggle_filter;
  localparam int NUM_EP = 16;
  localparam int EPW = 4;

  logic clk = 0, rst_n = 0;
  logic pkt_valid = 0, pkt_dir = 0, pkt_data1 = 0, pkt_crc_ok = 0;
  logic hs_mode = 0, room_now = 0, room_next = 0;
  logic [EPW-1:0] pkt_ep = '0;
  logic [2*NUM_EP-1:0] tog_clr = '0;
  logic acc_valid, drop_dup, rsp_valid, tog_upd_valid, tog_upd_dir, tog_upd_value;
  logic [1:0] rsp_code;
  logic [EPW-1:0] tog_upd_ep;

  int tests = 0, fails = 0;
  logic model [2*NUM_EP];

  always #10 clk = ~clk;

  usb_toggle_filter #(.NUM_EP(NUM_EP)) i_usb_toggle_filter (
    .clk, .rst_n, .pkt_valid, .pkt_ep, .pkt_dir, .pkt_data1, .pkt_crc_ok,
    .hs_mode, .room_now, .room_next, .tog_clr, .acc_valid, .drop_dup,
    .rsp_valid, .rsp_code, .tog_upd_valid, .tog_upd_ep, .tog_upd_dir, .tog_upd_value);

  task automatic chk(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic xfer(input string req, input int ep, input bit dir, input bit d1,
                      input bit crc, input bit hs, input bit rn, input bit rx,
                      input bit clr_same);
    int s; bit match, take, dup, busy; int code;
    s = ep * 2 + dir;
    match = (d1 == model[s]);
    take = crc && match && rn;
    busy = crc && match && !rn;
    dup  = crc && !match;
    code = busy ? 3 : (take || dup) ? ((hs && !rx) ? 2 : 1) : 0;
    @(negedge clk);
    pkt_valid = 1; pkt_ep = EPW'(ep); pkt_dir = dir; pkt_data1 = d1;
    pkt_crc_ok = crc; hs_mode = hs; room_now = rn; room_next = rx;
    if (clr_same) tog_clr[s] = 1'b1;
    @(negedge clk);
    pkt_valid = 0; tog_clr = '0;
    chk({req, " acc"}, acc_valid, take);
    chk({req, " drop"}, drop_dup, dup);
    chk({req, " code"}, rsp_code, code);
    chk({req, " rspv"}, rsp_valid, code != 0);
    chk({req, " upd"}, tog_upd_valid, take);
    if (take) begin
      chk({req, " upd_ep"}, tog_upd_ep, ep);
      chk({req, " upd_dir"}, tog_upd_dir, dir);
      chk({req, " upd_val"}, tog_upd_value, !model[s]);
      model[s] = clr_same ? 1'b0 : !model[s];
    end
    @(negedge clk);
    chk({req, " one-cycle R10"}, acc_valid | drop_dup | rsp_valid, 0);
  endtask

  task automatic t_reset();
    chk("R1 reset acc", acc_valid, 0);
    chk("R1 reset rsp", rsp_valid, 0);
    chk("R1 reset drop", drop_dup, 0);
    xfer("R1 first DATA0 accepted", 1, 0, 0, 1, 0, 1, 1, 0);
  endtask

  task automatic t_stream();
    for (int k = 0; k < 4; k++) xfer("R2 stream", 2, 0, model[4], 1, 0, 1, 1, 0);
  endtask

  task automatic t_dup();
    xfer("R2 before replay", 3, 0, model[6], 1, 0, 1, 1, 0);
    xfer("R3 replay dropped", 3, 0, !model[6], 1, 0, 1, 1, 0);
    xfer("R4 replay no room ACK", 3, 0, !model[6], 1, 0, 0, 0, 0);
    xfer("R4 replay hs NYET", 3, 0, !model[6], 1, 1, 0, 0, 0);
    xfer("R3 state kept", 3, 0, model[6], 1, 0, 1, 1, 0);
  endtask

  task automatic t_crc();
    xfer("R5 bad crc match", 4, 0, model[8], 0, 1, 1, 1, 0);
    xfer("R5 bad crc mismatch", 4, 0, !model[8], 0, 0, 1, 1, 0);
    xfer("R5 toggle unchanged", 4, 0, model[8], 1, 0, 1, 1, 0);
  endtask

  task automatic t_nak_nyet();
    xfer("R7 no room NAK", 5, 0, model[10], 1, 1, 0, 0, 0);
    xfer("R6 hs next full NYET", 5, 0, model[10], 1, 1, 1, 0, 0);
    xfer("R6 hs next room ACK", 5, 0, model[10], 1, 1, 1, 1, 0);
    xfer("R6 fs next full ACK", 5, 0, model[10], 1, 0, 1, 0, 0);
  endtask

  task automatic t_clear();
    xfer("R8 prep", 6, 1, model[13], 1, 0, 1, 1, 0);
    @(negedge clk); tog_clr[13] = 1'b1; @(negedge clk); tog_clr = '0;
    model[13] = 1'b0;
    xfer("R8 after clear DATA0 taken", 6, 1, 0, 1, 0, 1, 1, 0);
    xfer("R8 clear beats flip", 6, 1, 1, 1, 0, 1, 1, 1);
    xfer("R8 DATA0 expected again", 6, 1, 0, 1, 0, 1, 1, 0);
  endtask

  task automatic t_indep();
    xfer("R9 slot out", 7, 0, model[14], 1, 0, 1, 1, 0);
    xfer("R9 slot in untouched", 7, 1, 0, 1, 0, 1, 1, 0);
    xfer("R9 other ep untouched", 8, 0, 0, 1, 0, 1, 1, 0);
    xfer("R9 slot out advanced", 7, 0, 1, 1, 0, 1, 1, 0);
  endtask

  initial begin
    for (int i = 0; i < 2 * NUM_EP; i++) model[i] = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_stream();
    t_dup();
    t_crc();
    t_nak_nyet();
    t_clear();
    t_indep();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #1000000;
    tests++; fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule